// File: doc/BRIEF.md
# Root Port Interrupt Status Aggregator

This block gathers interrupt events arriving from the link side of a root port and presents them to software in a two-level hierarchy. Legacy INTA–INTD assert and deassert events, message-signalled interrupt (MSI) arrivals, power-state-change pulses and flush pulses are latched into two first-level status registers. Each register has a companion mask. MSI arrivals are also recorded per vector in a 32-entry status vector that has its own mask. The 16-bit payload of the most recent message is captured so that software can identify the message.

Any unmasked, valid bit in either first-level register drives a core summary bit in a top-level host status register. That register has its own mask, and its unmasked bits are ORed into a single interrupt output. All status registers are write-one-to-clear. When hardware sets a bit in the same cycle that software clears it, the set takes priority, so no event is lost. Software reaches every register through a simple word-addressed read/write port. Reads are combinational, and writes take effect at the clock edge.

Top module: `rp_irq_agg`

## Requirements
- R1: After reset, all status registers and the payload register read 0. Mask A reads 0x07FFFFFF, mask B reads 0x00000FF0, the MSI mask reads 0xFFFFFFFF, the host mask reads 0x00FFF0FB, and `irq_out` is 0.
- R2: Status A is at address 0, and its valid bits are 26:0. A pulse on `intx_assert[i]` sets bit 16+i, and a pulse on `intx_deassert[i]` sets bit 20+i. Each bit stays set until it is cleared. Bits 31:27 always read 0.
- R3: Status B is at address 2, and its valid bits are 11:4. `pm_change` sets bit 4, `flush_evt` sets bit 5, and `intx_assert[i]` sets bit 8+i. All other bits read 0.
- R4: Writing a status register clears exactly the valid bits written as 1. Bits written as 0 keep their value. Mask A (address 1) and mask B (address 3) store the written value restricted to their register's valid bits.
- R5: An MSI arrival with index k sets bit k of the MSI status register (address 4) and loads its payload into the payload register (address 6). Writing 1 to a bit of address 4 clears only that vector.
- R6: An MSI arrival sets the pending bit 24 of status A only when bit k of the MSI mask (address 5, 1 = masked) is 0. The MSI status bit is set in either case.
- R7: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Host status bit 16 (address 7) becomes 1 at the clock edge after any bit of status A or status B is set while its mask bit is 0. Host status is write-one-to-clear and reads only within pattern 0x00FFF0FB.
- R9: `irq_out` is high exactly while some bit of host status is set and the same bit of the host mask (address 8, 1 = masked) is 0.
- R10: Writes to the payload register and to addresses 9–15 have no effect, and reads of addresses 9–15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intx_assert | input | 4 | Legacy INTA–INTD assert event pulses |
| intx_deassert | input | 4 | Legacy INTA–INTD deassert event pulses |
| msi_valid | input | 1 | MSI arrival strobe |
| msi_index | input | 5 | Vector index of the arriving MSI |
| msi_payload | input | 16 | Payload of the arriving MSI |
| pm_change | input | 1 | Power-state-change event pulse |
| flush_evt | input | 1 | Flush event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Summary interrupt output |

## Verification
A hardware event and a software write-one-to-clear can land on the same status bit in the same clock cycle. The same is true of an MSI arrival and a clear of its vector, and of a first-level summary and a clear of host bit 16. The bench provokes each collision directly, for example an INTA assert together with a clear of bit 16. It also produces them in large numbers through random events mixed with random all-ones clear writes. The result is judged by reading the register in the following cycle and comparing it against a bench model in which the set always wins. The same model also predicts the one-cycle lag from a first-level bit to host bit 16 and on to `irq_out`.

// File: rtl/rp_irq_agg.sv
module rp_irq_agg #(
  parameter int MSI_N     = 32,
  parameter int PAYLOAD_W = 16,
  parameter int ADDR_W    = 4,
  localparam int IDX_W    = $clog2(MSI_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           intx_assert,
  input  logic [3:0]           intx_deassert,
  input  logic                 msi_valid,
  input  logic [IDX_W-1:0]     msi_index,
  input  logic [PAYLOAD_W-1:0] msi_payload,
  input  logic                 pm_change,
  input  logic                 flush_evt,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq_out
);

  localparam logic [31:0] VALID_A   = 32'h07FF_FFFF;
  localparam logic [31:0] VALID_B   = 32'h0000_0FF0;
  localparam logic [31:0] HOST_IMPL = 32'h00FF_F0FB;
  localparam int CORE_BIT  = 16;
  localparam int PEND_BIT  = 24;

  localparam logic [ADDR_W-1:0] AD_STA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AD_MSKA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] AD_STB  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] AD_MSKB = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] AD_MSIS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] AD_MSIM = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] AD_PAY  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] AD_HST  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] AD_HMSK = ADDR_W'(8);

  logic [31:0]          stat_a_q, stat_b_q, mask_a_q, mask_b_q;
  logic [31:0]          host_stat_q, host_mask_q;
  logic [MSI_N-1:0]     msi_stat_q, msi_mask_q;
  logic [PAYLOAD_W-1:0] pay_q;

  logic wr_sta, wr_mska, wr_stb, wr_mskb, wr_msis, wr_msim, wr_hst, wr_hmsk;
  assign wr_sta  = reg_wr && reg_addr == AD_STA;
  assign wr_mska = reg_wr && reg_addr == AD_MSKA;
  assign wr_stb  = reg_wr && reg_addr == AD_STB;
  assign wr_mskb = reg_wr && reg_addr == AD_MSKB;
  assign wr_msis = reg_wr && reg_addr == AD_MSIS;
  assign wr_msim = reg_wr && reg_addr == AD_MSIM;
  assign wr_hst  = reg_wr && reg_addr == AD_HST;
  assign wr_hmsk = reg_wr && reg_addr == AD_HMSK;

  logic [31:0] set_a, set_b, clr_a, clr_b, clr_h;
  logic [MSI_N-1:0] msi_set, msi_clr;
  logic msi_open, core_sum;

  assign msi_open = msi_valid && !msi_mask_q[msi_index];

  always_comb begin
    set_a = '0;
    set_a[19:16]    = intx_assert;
    set_a[23:20]    = intx_deassert;
    set_a[PEND_BIT] = msi_open;
    set_b = '0;
    set_b[4]    = pm_change;
    set_b[5]    = flush_evt;
    set_b[11:8] = intx_assert;
  end

  assign clr_a   = wr_sta  ? reg_wdata : '0;
  assign clr_b   = wr_stb  ? reg_wdata : '0;
  assign clr_h   = wr_hst  ? reg_wdata : '0;
  assign msi_clr = wr_msis ? reg_wdata[MSI_N-1:0] : '0;
  assign msi_set = msi_valid ? (MSI_N'(1) << msi_index) : '0;

  assign core_sum = |(stat_a_q & ~mask_a_q) || |(stat_b_q & ~mask_b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_a_q    <= '0;
      stat_b_q    <= '0;
      mask_a_q    <= VALID_A;
      mask_b_q    <= VALID_B;
      msi_stat_q  <= '0;
      msi_mask_q  <= '1;
      pay_q       <= '0;
      host_stat_q <= '0;
      host_mask_q <= HOST_IMPL;
    end else begin
      stat_a_q    <= ((stat_a_q & ~clr_a) | set_a) & VALID_A;
      stat_b_q    <= ((stat_b_q & ~clr_b) | set_b) & VALID_B;
      msi_stat_q  <= (msi_stat_q & ~msi_clr) | msi_set;
      host_stat_q <= ((host_stat_q & ~clr_h) | (32'(core_sum) << CORE_BIT)) & HOST_IMPL;
      if (wr_mska) mask_a_q    <= reg_wdata & VALID_A;
      if (wr_mskb) mask_b_q    <= reg_wdata & VALID_B;
      if (wr_msim) msi_mask_q  <= reg_wdata[MSI_N-1:0];
      if (wr_hmsk) host_mask_q <= reg_wdata & HOST_IMPL;
      if (msi_valid) pay_q     <= msi_payload;
    end
  end

  always_comb begin
    case (reg_addr)
      AD_STA:  reg_rdata = stat_a_q;
      AD_MSKA: reg_rdata = mask_a_q;
      AD_STB:  reg_rdata = stat_b_q;
      AD_MSKB: reg_rdata = mask_b_q;
      AD_MSIS: reg_rdata = 32'(msi_stat_q);
      AD_MSIM: reg_rdata = 32'(msi_mask_q);
      AD_PAY:  reg_rdata = 32'(pay_q);
      AD_HST:  reg_rdata = host_stat_q;
      AD_HMSK: reg_rdata = host_mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_out = |(host_stat_q & ~host_mask_q);

endmodule

// File: rtl/rp_irq_agg_chk.sv
module rp_irq_agg_chk #(
  parameter int MSI_N  = 32,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(MSI_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        intx_assert,
  input logic              msi_valid,
  input logic [IDX_W-1:0]  msi_index,
  input logic              pm_change,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq_out,
  input logic [31:0]       stat_a_q,
  input logic [31:0]       stat_b_q,
  input logic [31:0]       mask_a_q,
  input logic [31:0]       mask_b_q,
  input logic [31:0]       host_stat_q,
  input logic [31:0]       host_mask_q,
  input logic [MSI_N-1:0]  msi_stat_q,
  input logic [MSI_N-1:0]  msi_mask_q
);

  p_intx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert[0] |=> stat_a_q[16]);

  p_pm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_change |=> stat_b_q[4]);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[4] && !pm_change) |=> !stat_b_q[4]);

  p_msi_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> msi_stat_q[$past(msi_index)]);

  p_pend_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_mask_q[msi_index]) |=> stat_a_q[24]);

  p_core_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_a_q & ~mask_a_q) || |(stat_b_q & ~mask_b_q)) |=> host_stat_q[16]);

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (host_stat_q[16] && !host_mask_q[16]));

endmodule

bind rp_irq_agg rp_irq_agg_chk #(.MSI_N(MSI_N), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rp_irq_agg_tb.sv
`timescale 1ns/10ps
module rp_irq_agg_tb;

  localparam logic [31:0] VA = 32'h07FF_FFFF;
  localparam logic [31:0] VB = 32'h0000_0FF0;
  localparam logic [31:0] HI = 32'h00FF_F0FB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_assert = '0, intx_deassert = '0;
  logic        msi_valid = 1'b0;
  logic [4:0]  msi_index = '0;
  logic [15:0] msi_payload = '0;
  logic        pm_change = 1'b0, flush_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  always #4 clk = ~clk;

  rp_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .intx_assert(intx_assert), .intx_deassert(intx_deassert),
    .msi_valid(msi_valid), .msi_index(msi_index), .msi_payload(msi_payload),
    .pm_change(pm_change), .flush_evt(flush_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] ma, mb, mma, mmb, mms, mmm, mp, mh, mhm;

  function automatic logic [31:0] exp_read(int a);
    case (a)
      0: return ma;  1: return mma; 2: return mb;  3: return mmb;
      4: return mms; 5: return mmm; 6: return mp;  7: return mh;
      8: return mhm; default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2"; 1: return "R4"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R5"; 7: return "R8";
      8: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(mh & ~mhm & HI);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string over);
    for (int a = 0; a < 10; a++) begin
      reg_addr = 4'(a);
      #0.3;
      chk(over != "" ? over : tag_of(a), reg_rdata, exp_read(a));
    end
    chk(over != "" ? over : "R9", 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic step(logic [3:0] ia, logic [3:0] id, logic mv, logic [4:0] mi,
                      logic [15:0] pl, logic pm, logic fl,
                      logic w, logic [3:0] wa, logic [31:0] wd, string tag);
    logic [31:0] sa, sb, ca, cb, ch, cm;
    logic summ;
    @(negedge clk);
    intx_assert = '0; intx_deassert = '0; msi_valid = 0; pm_change = 0;
    flush_evt = 0; reg_wr = 0;
    check_all(tag);
    intx_assert = ia; intx_deassert = id; msi_valid = mv; msi_index = mi;
    msi_payload = pl; pm_change = pm; flush_evt = fl;
    reg_wr = w; reg_addr = wa; reg_wdata = wd;
    sa = '0; sa[19:16] = ia; sa[23:20] = id; sa[24] = mv && !mmm[mi];
    sb = '0; sb[4] = pm; sb[5] = fl; sb[11:8] = ia;
    ca = (w && wa == 0) ? wd : 0;
    cb = (w && wa == 2) ? wd : 0;
    cm = (w && wa == 4) ? wd : 0;
    ch = (w && wa == 7) ? wd : 0;
    summ = |(ma & ~mma) || |(mb & ~mmb);
    @(posedge clk);
    ma = ((ma & ~ca) | sa) & VA;
    mb = ((mb & ~cb) | sb) & VB;
    mms = (mms & ~cm) | (mv ? (32'h1 << mi) : 32'h0);
    mh = ((mh & ~ch) | (32'(summ) << 16)) & HI;
    if (w && wa == 1) mma = wd & VA;
    if (w && wa == 3) mmb = wd & VB;
    if (w && wa == 5) mmm = wd;
    if (w && wa == 8) mhm = wd & HI;
    if (mv) mp = 32'(pl);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, d, "");
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    ma = 0; mb = 0; mms = 0; mp = 0; mh = 0;
    mma = VA; mmb = VB; mmm = 32'hFFFF_FFFF; mhm = HI;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");
    // events with everything masked: stored, no irq (R8, R9)
    step(4'b0100, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1");
    idle("R2"); idle("R8");
    wr(1, 32'h0); wr(3, 32'h0); wr(5, 32'h0);
    wr(8, HI & ~32'h0001_0000);
    idle("R8"); idle("R9");
    // R7: set and clear of the same bit in one cycle
    step(4'b0001, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0001_0000, "");
    idle("R7");
    step(0, 0, 0, 0, 0, 1, 0, 1, 2, 32'h10, "");
    idle("R7");
    // R6: masked vector sets status only
    wr(5, 32'h0000_0020);
    wr(0, 32'hFFFF_FFFF);
    step(0, 0, 1, 5, 16'hBEEF, 0, 0, 0, 0, 0, "");
    idle("R6");
    step(0, 0, 1, 9, 16'h1234, 0, 0, 1, 4, 32'h200, "");
    idle("R7");
    // R10: payload and unused addresses ignore writes
    wr(6, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF);
    idle("R10");
    // R9: clear everything, irq falls
    wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    idle("R9"); idle("R9");
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [3:0] wa;
      logic [31:0] wd;
      w  = ($urandom % 10) < 3;
      wa = 4'($urandom % 11);
      wd = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
      if (wa == 1 || wa == 3 || wa == 8) wd = ($urandom % 3 == 0) ? $urandom : 32'h0;
      if (wa == 5) wd = $urandom & $urandom;
      step(($urandom % 4 == 0) ? 4'($urandom) : 4'h0,
           ($urandom % 5 == 0) ? 4'($urandom) : 4'h0,
           ($urandom % 4 == 0), 5'($urandom), 16'($urandom),
           ($urandom % 8 == 0), ($urandom % 8 == 0), w, wa, wd, "");
    end
    idle("");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule